// File: doc/BRIEF.md
# Target Bus-Phase Sequencer

This block is the target end of a parallel peripheral bus after arbitration has finished. It watches the bus for a selection aimed at its own ID, answers by driving BSY, and then carries a whole command through to completion. The phase of each byte is shown to the initiator on three control lines (C/D, I/O, MSG). Every byte moves under an interlocked REQ/ACK handshake, and the order of that handshake depends on which side is sending.

The block first takes in the command bytes. The length of the command comes from the group field in the top three bits of the first byte. Next comes an optional data phase, whose direction and byte count the local logic supplies. The block then sends one status byte and one command-complete message byte, releases the bus, and returns to idle. On the local side it reports each received byte with a strobe, and it takes each outgoing data byte with a take pulse. Odd parity on the ninth data line is generated and checked whenever parity is enabled. A parity error on a received byte, or an unknown command group, turns the status byte into an error code.

Top module: `tgt_phase_seq`

## Requirements
- R1: `bsy_o` rises after the SETTLE_CYC-th consecutive rising clock edge at which `sel_i` is high, bit `own_id` of `db_i` is high, and `bsy_i` and `io_i` are both low. A shorter hold, a different ID bit, or `io_i` high leaves `bsy_o` low.
- R2: While a byte is in transfer, the lines {`cd_o`,`io_o`,`msg_o`} show the phase with these codes: command 3'b100, data-in 3'b010, data-out 3'b000, status 3'b110, message 3'b111. The lines do not change while `req_o` is held.
- R3: When the initiator sends (command, data-out), `req_o` goes high. On the edge where `ack_i` is seen, the block captures `db_i` and drops `req_o`, and `rx_stb` pulses for one cycle with the byte on `rx_byte`. The next `req_o` comes only after `ack_i` has been seen low.
- R4: When the target sends (data-in, status, message), `db_oe` is high with the byte on `db_o` for DESKEW_CYC+SKEW_CYC cycles before `req_o` rises. Seeing `ack_i` drops both `req_o` and `db_oe`. The next byte starts only after `ack_i` is low.
- R5: The command length comes from bits 7:5 of the first command byte: group 0 gives 6 bytes, groups 1 and 2 give 10 bytes, and group 5 gives 12 bytes.
- R6: Any other group ends the command phase after its first byte, skips the data phase, and sends status 8'h02.
- R7: With `par_en` high, `dbp_o` is the odd-parity bit of `db_o`. A received byte whose nine bits hold an even number of ones is latched as an error, and the status then becomes 8'h02. With `par_en` low, `dbp_o` is 0 and received parity is ignored.
- R8: The phase order is command, then data, then status, then message. `xfer_in` and `xfer_len` are sampled when the command phase ends, and an `xfer_len` of 0 skips the data phase. Status is `stat_byte` unless an error was latched. The message byte is 8'h00. After the message byte, `bsy_o`, `req_o`, `db_oe` and the phase lines are all low, and a new selection is accepted SETTLE_CYC cycles later.
- R9: Each data-in byte is loaded from `tx_byte` with a one-cycle `tx_take` pulse, one pulse per byte. Data-out bytes appear on `rx_stb` with `rx_is_cmd` low, and command bytes appear with `rx_is_cmd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| own_id | input | 3 | Index of this target's ID bit on the data bus |
| par_en | input | 1 | Enables parity generation and checking |
| sel_i | input | 1 | Bus SEL |
| bsy_i | input | 1 | BSY driven by other devices |
| io_i | input | 1 | Bus I/O as seen during selection |
| ack_i | input | 1 | Bus ACK |
| db_i | input | 8 | Bus data in |
| dbp_i | input | 1 | Bus parity bit in |
| bsy_o | output | 1 | BSY driven by this target |
| req_o | output | 1 | REQ |
| cd_o | output | 1 | Phase line C/D |
| io_o | output | 1 | Phase line I/O |
| msg_o | output | 1 | Phase line MSG |
| db_o | output | 8 | Bus data out |
| dbp_o | output | 1 | Bus parity bit out |
| db_oe | output | 1 | Data bus drive enable |
| xfer_in | input | 1 | Data phase direction, 1 = data-in |
| xfer_len | input | 8 | Data phase byte count |
| stat_byte | input | 8 | Status byte from local logic |
| tx_byte | input | 8 | Next data-in byte |
| tx_take | output | 1 | Pulse: `tx_byte` was taken |
| rx_stb | output | 1 | Pulse: a received byte is on `rx_byte` |
| rx_byte | output | 8 | Received byte |
| rx_is_cmd | output | 1 | The received byte belongs to the command phase |

## Verification
The bench selects with a hold one cycle short, with the wrong ID bit and with I/O high; a detector that counts one edge early, or ignores a qualifier, would raise BSY in one of these. It runs commands of every valid group length and one unknown group. A wrong length table would show up as an extra or missing REQ in the command phase, or as a status other than 02. It corrupts parity with checking on and again with checking off, so that inverted parity or ignored enables show up in the status byte and on `dbp_o`. It runs both data directions and a zero-length data phase. On every target-sent byte it measures the cycles between data drive and REQ, so a shortened setup window or a REQ raised while ACK is still high is caught.

// File: rtl/tgt_phase_pkg.sv
package tgt_phase_pkg;

  localparam int DATA_W = 8;
  localparam int ID_W   = $clog2(DATA_W);

  localparam logic [DATA_W-1:0] STATUS_ERR = 8'h02;
  localparam logic [DATA_W-1:0] MSG_DONE   = 8'h00;

  typedef enum logic [2:0] {PH_CMD, PH_DIN, PH_DOUT, PH_STAT, PH_MSG} phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SELD, S_RX_REQ, S_RX_ACK, S_TX_SET, S_TX_REQ, S_TX_ACK, S_FREE
  } state_e;

  // {C/D, I/O, MSG} for each phase
  function automatic logic [2:0] ph_lines(input phase_e p);
    case (p)
      PH_CMD:  ph_lines = 3'b100;
      PH_DIN:  ph_lines = 3'b010;
      PH_STAT: ph_lines = 3'b110;
      PH_MSG:  ph_lines = 3'b111;
      default: ph_lines = 3'b000;
    endcase
  endfunction

  function automatic logic ph_target_sends(input phase_e p);
    ph_target_sends = (p == PH_DIN) || (p == PH_STAT) || (p == PH_MSG);
  endfunction

  // Command length from the group field; 0 marks an unknown group
  function automatic logic [3:0] cmd_len(input logic [DATA_W-1:0] b);
    case (b[DATA_W-1 -: 3])
      3'd0:       cmd_len = 4'd6;
      3'd1, 3'd2: cmd_len = 4'd10;
      3'd5:       cmd_len = 4'd12;
      default:    cmd_len = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/tgt_sel_detect.sv
module tgt_sel_detect
  import tgt_phase_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              bsy_i,
  input  logic              io_i,
  input  logic [DATA_W-1:0] db_i,
  input  logic [ID_W-1:0]   own_id,
  output logic              hit
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic          qual;
  logic [CW-1:0] held;

  assign qual = sel_i && db_i[own_id] && !bsy_i && !io_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          held <= '0;
    else if (!qual)                      held <= '0;
    else if (held != CW'(SETTLE_CYC))    held <= held + 1'b1;
  end

  assign hit = qual && (held >= CW'(SETTLE_CYC - 1));

  generate
    if (SETTLE_CYC > 1) begin : g_chk
      AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(qual)) else $error("selection hit without prior hold"); // R1
    end
  endgenerate

endmodule

// File: rtl/tgt_parity.sv
module tgt_parity
  import tgt_phase_pkg::*;
(
  input  logic              en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_p,
  output logic              tx_p,
  output logic              rx_err
);
  // odd parity: nine bits together hold an odd number of ones
  assign tx_p   = en ? ~(^tx_data) : 1'b0;
  assign rx_err = en && !(^{rx_data, rx_p});
endmodule

// File: rtl/tgt_phase_seq.sv
module tgt_phase_seq
  import tgt_phase_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int DESKEW_CYC = 2,
  parameter int SKEW_CYC   = 1,
  parameter int LEN_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   own_id,
  input  logic              par_en,
  input  logic              sel_i,
  input  logic              bsy_i,
  input  logic              io_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] db_i,
  input  logic              dbp_i,
  output logic              bsy_o,
  output logic              req_o,
  output logic              cd_o,
  output logic              io_o,
  output logic              msg_o,
  output logic [DATA_W-1:0] db_o,
  output logic              dbp_o,
  output logic              db_oe,
  input  logic              xfer_in,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [DATA_W-1:0] stat_byte,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_take,
  output logic              rx_stb,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_is_cmd
);
  localparam int TX_SETUP = DESKEW_CYC + SKEW_CYC;
  localparam int TMR_MAX  = (TX_SETUP > SETTLE_CYC) ? TX_SETUP : SETTLE_CYC;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);

  state_e             state;
  phase_e             phase, next_ph;
  logic [LEN_W-1:0]   cnt;
  logic [TMR_W-1:0]   tmr;
  logic [DATA_W-1:0]  db_q, stat_val;
  logic               first, grp_bad, perr;
  logic               sel_hit, rx_perr, in_xfer, byte_end, last_byte;
  logic [3:0]         len0;

  tgt_sel_detect #(.SETTLE_CYC(SETTLE_CYC)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .bsy_i(bsy_i), .io_i(io_i),
    .db_i(db_i), .own_id(own_id), .hit(sel_hit)
  );

  tgt_parity u_par (
    .en(par_en), .tx_data(db_q), .rx_data(db_i), .rx_p(dbp_i),
    .tx_p(dbp_o), .rx_err(rx_perr)
  );

  assign len0      = cmd_len(db_i);
  assign byte_end  = (state == S_RX_ACK || state == S_TX_ACK) && !ack_i;
  assign last_byte = (cnt == '0);
  assign stat_val  = (perr || grp_bad) ? STATUS_ERR : stat_byte;

  always_comb begin
    case (phase)
      PH_CMD:  next_ph = (grp_bad || xfer_len == '0) ? PH_STAT :
                         (xfer_in ? PH_DIN : PH_DOUT);
      PH_STAT: next_ph = PH_MSG;
      PH_MSG:  next_ph = PH_MSG;
      default: next_ph = PH_STAT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; phase <= PH_CMD; cnt <= '0; tmr <= '0; db_q <= '0;
      first <= 1'b0; grp_bad <= 1'b0; perr <= 1'b0;
      tx_take <= 1'b0; rx_stb <= 1'b0; rx_byte <= '0; rx_is_cmd <= 1'b0;
    end else begin
      tx_take <= 1'b0;
      rx_stb  <= 1'b0;
      case (state)
        S_IDLE: if (sel_hit) begin
          state <= S_SELD; grp_bad <= 1'b0; perr <= 1'b0;
        end
        S_SELD: if (!sel_i) begin
          phase <= PH_CMD; first <= 1'b1; state <= S_RX_REQ;
        end
        S_RX_REQ: if (ack_i) begin
          state     <= S_RX_ACK;
          first     <= 1'b0;
          rx_stb    <= 1'b1;
          rx_byte   <= db_i;
          rx_is_cmd <= (phase == PH_CMD);
          if (rx_perr) perr <= 1'b1;
          if (first) begin
            if (len0 == 4'd0) begin grp_bad <= 1'b1; cnt <= '0; end
            else cnt <= LEN_W'(len0 - 4'd1);
          end else cnt <= cnt - 1'b1;
        end
        S_TX_SET: if (tmr == '0) state <= S_TX_REQ; else tmr <= tmr - 1'b1;
        S_TX_REQ: if (ack_i) begin state <= S_TX_ACK; cnt <= cnt - 1'b1; end
        S_FREE:   if (tmr == '0) state <= S_IDLE; else tmr <= tmr - 1'b1;
        default: ;
      endcase

      if (byte_end) begin
        if (!last_byte) begin
          if (ph_target_sends(phase)) begin
            state <= S_TX_SET; tmr <= TMR_W'(TX_SETUP - 1);
            db_q <= tx_byte; tx_take <= 1'b1;
          end else state <= S_RX_REQ;
        end else if (phase == PH_MSG) begin
          state <= S_FREE; tmr <= TMR_W'(SETTLE_CYC - 1);
        end else begin
          phase <= next_ph;
          cnt   <= (next_ph == PH_DIN || next_ph == PH_DOUT) ? xfer_len : LEN_W'(1);
          if (ph_target_sends(next_ph)) begin
            state   <= S_TX_SET;
            tmr     <= TMR_W'(TX_SETUP - 1);
            db_q    <= (next_ph == PH_DIN) ? tx_byte :
                       (next_ph == PH_STAT) ? stat_val : MSG_DONE;
            tx_take <= (next_ph == PH_DIN);
          end else state <= S_RX_REQ;
        end
      end
    end
  end

  assign in_xfer = (state == S_RX_REQ) || (state == S_RX_ACK) || (state == S_TX_SET) ||
                   (state == S_TX_REQ) || (state == S_TX_ACK);
  assign {cd_o, io_o, msg_o} = in_xfer ? ph_lines(phase) : 3'b000;
  assign req_o = (state == S_RX_REQ) || (state == S_TX_REQ);
  assign db_oe = (state == S_TX_SET) || (state == S_TX_REQ);
  assign bsy_o = (state != S_IDLE) && (state != S_FREE);
  assign db_o  = db_q;

  // cycles the data bus has been driven, saturating, for the setup check
  logic [TMR_W:0] oe_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             oe_age <= '0;
    else if (!db_oe)                        oe_age <= '0;
    else if (oe_age != (TMR_W+1)'(TMR_MAX)) oe_age <= oe_age + 1'b1;
  end

  AST_BSY_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && sel_hit) |=> bsy_o) else $error("no BSY after select"); // R1
  AST_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && $past(req_o)) |-> $stable({cd_o, io_o, msg_o})) else $error("phase moved under REQ"); // R2
  AST_REQ_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(!ack_i)) else $error("REQ raised while ACK high"); // R3
  AST_TX_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_o) && io_o) |-> (oe_age >= (TMR_W+1)'(TX_SETUP))) else $error("REQ before data setup"); // R4
  AST_RX_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |-> $past(ack_i && req_o)) else $error("capture without handshake"); // R3
  AST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !bsy_o |-> (!req_o && !db_oe && {cd_o, io_o, msg_o} == 3'b000)) else $error("bus held after release"); // R8

endmodule

// File: tb/sim_tgt_phase_seq.sv
`timescale 1ns/1ps
module sim_tgt_phase_seq;
  localparam int SETTLE = 4;
  localparam int TXS    = 3;   // deskew 2 + skew 1
  localparam logic [2:0] OWN = 3'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [2:0] own_id = OWN;
  logic par_en = 1'b1, sel_i = 1'b0, bsy_i = 1'b0, io_i = 1'b0, ack_i = 1'b0, dbp_i = 1'b0;
  logic [7:0] sel_db = '0, rsp_db = '0, db_i;
  logic xfer_in = 1'b0;
  logic [7:0] xfer_len = '0, stat_byte = '0, tx_byte;
  logic bsy_o, req_o, cd_o, io_o, msg_o, dbp_o, db_oe, tx_take, rx_stb, rx_is_cmd;
  logic [7:0] db_o, rx_byte;

  assign db_i = sel_db | rsp_db;

  tgt_phase_seq u0 (
    .clk(clk), .rst_n(rst_n), .own_id(own_id), .par_en(par_en), .sel_i(sel_i),
    .bsy_i(bsy_i), .io_i(io_i), .ack_i(ack_i), .db_i(db_i), .dbp_i(dbp_i),
    .bsy_o(bsy_o), .req_o(req_o), .cd_o(cd_o), .io_o(io_o), .msg_o(msg_o),
    .db_o(db_o), .dbp_o(dbp_o), .db_oe(db_oe), .xfer_in(xfer_in), .xfer_len(xfer_len),
    .stat_byte(stat_byte), .tx_byte(tx_byte), .tx_take(tx_take), .rx_stb(rx_stb),
    .rx_byte(rx_byte), .rx_is_cmd(rx_is_cmd)
  );

  int vectors = 0, miscompares = 0, cyc = 0, take_cnt = 0, oe_cnt = 0;

  // expected traffic, built per scenario
  logic [2:0] exp_ph[$];
  logic [7:0] exp_tx[$];
  logic [7:0] send_q[$];
  bit         send_bad[$];
  logic [7:0] rx_exp[$];
  bit         rx_kind[$];

  function automatic logic [7:0] din_val(input int k);
    return 8'h5A + 8'(k * 19);
  endfunction
  assign tx_byte = din_val(take_cnt);

  function automatic int ref_len(input logic [7:0] b);
    if (b < 8'h20) return 6;
    if (b < 8'h60) return 10;
    if (b >= 8'hA0 && b < 8'hC0) return 12;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // initiator responder and per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      oe_cnt = db_oe ? oe_cnt + 1 : 0;
      if (tx_take) take_cnt++;
      if (rx_stb) begin
        if (rx_exp.size() == 0) check(0, "R3 unexpected rx_stb", rx_byte, 0);
        else begin
          check(rx_byte == rx_exp[0], "R3 received byte", rx_byte, rx_exp[0]);
          check(rx_is_cmd == rx_kind[0], "R9 rx_is_cmd", rx_is_cmd, rx_kind[0]);
          void'(rx_exp.pop_front()); void'(rx_kind.pop_front());
        end
      end
      if (req_o && !ack_i) begin
        if (exp_ph.size() == 0) check(0, "R8 extra REQ", {cd_o, io_o, msg_o}, 0);
        else begin
          check({cd_o, io_o, msg_o} == exp_ph[0], "R2 phase lines", {cd_o, io_o, msg_o}, exp_ph[0]);
          void'(exp_ph.pop_front());
        end
        if (io_o) begin
          logic [7:0] ev;
          ev = (exp_tx.size() != 0) ? exp_tx.pop_front() : 8'hxx;
          check(db_o == ev, "R4 sent byte", db_o, ev);
          check(dbp_o == (par_en ? ~(^ev) : 1'b0), "R7 sent parity", dbp_o, par_en ? ~(^ev) : 1'b0);
          check(oe_cnt == TXS + 1, "R4 data setup cycles", oe_cnt, TXS + 1);
        end else begin
          logic [7:0] b; bit bad;
          b   = (send_q.size() != 0) ? send_q.pop_front() : 8'h00;
          bad = (send_bad.size() != 0) ? send_bad.pop_front() : 1'b0;
          rsp_db = b;
          dbp_i  = ~(^b) ^ bad;
        end
        ack_i = 1'b1;
      end else if (!req_o && ack_i) begin
        ack_i = 1'b0; rsp_db = '0; dbp_i = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic try_select(input logic [7:0] mask, input logic io, input int hold, input string tag);
    @(negedge clk);
    sel_db = mask; sel_i = 1'b1; io_i = io;
    repeat (hold) @(negedge clk);
    check(bsy_o == 1'b0, tag, bsy_o, 0);
    sel_db = '0; sel_i = 1'b0; io_i = 1'b0;
    repeat (3) @(negedge clk);
    check(bsy_o == 1'b0, tag, bsy_o, 0);
  endtask

  task automatic run(input logic [7:0] b0, input bit xin, input int xlen, input logic [7:0] st,
                     input bit pen, input int bad_idx, input logic [7:0] exp_st);
    int n, waitc;
    n = ref_len(b0);
    par_en = pen; xfer_in = xin; xfer_len = 8'(xlen); stat_byte = st; take_cnt = 0;
    for (int i = 0; i < (n == 0 ? 1 : n); i++) begin
      logic [7:0] v;
      v = (i == 0) ? b0 : 8'(8'h10 + i);
      send_q.push_back(v); send_bad.push_back(i == bad_idx);
      exp_ph.push_back(3'b100); rx_exp.push_back(v); rx_kind.push_back(1'b1);
    end
    if (n != 0 && xlen > 0) begin
      for (int k = 0; k < xlen; k++) begin
        if (xin) begin exp_ph.push_back(3'b010); exp_tx.push_back(din_val(k)); end
        else begin
          exp_ph.push_back(3'b000); send_q.push_back(8'(8'hC0 + k)); send_bad.push_back(1'b0);
          rx_exp.push_back(8'(8'hC0 + k)); rx_kind.push_back(1'b0);
        end
      end
    end
    exp_ph.push_back(3'b110); exp_tx.push_back(exp_st);
    exp_ph.push_back(3'b111); exp_tx.push_back(8'h00);
    // selection: exactly SETTLE qualifying edges
    @(negedge clk);
    sel_db = 8'h80 | (8'h01 << OWN); sel_i = 1'b1;
    waitc = 0;
    while (!bsy_o && waitc < 40) begin @(negedge clk); waitc++; end
    check(waitc == SETTLE, "R1 select-to-BSY edges", waitc, SETTLE);
    sel_db = '0; sel_i = 1'b0;
    waitc = 0;
    while (bsy_o && waitc < 4000) begin @(negedge clk); waitc++; end
    check(!bsy_o && !req_o && !db_oe && {cd_o, io_o, msg_o} == 3'b000, "R8 bus released",
          {bsy_o, req_o, db_oe, cd_o, io_o, msg_o}, 0);
    check(exp_ph.size() == 0 && exp_tx.size() == 0, "R8 all phases run", exp_ph.size(), 0);
    check(send_q.size() == 0 && rx_exp.size() == 0, "R5 command length", send_q.size() + rx_exp.size(), 0);
    check(take_cnt == ((n != 0 && xin) ? xlen : 0), "R9 tx_take count", take_cnt, (n != 0 && xin) ? xlen : 0);
    exp_ph.delete(); exp_tx.delete(); send_q.delete(); send_bad.delete(); rx_exp.delete(); rx_kind.delete();
    repeat (SETTLE + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(bsy_o == 0 && req_o == 0 && db_oe == 0 && rx_stb == 0, "R8 reset state",
          {bsy_o, req_o, db_oe, rx_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    try_select(8'h80 | (8'h01 << OWN), 1'b0, SETTLE - 1, "R1 short hold");
    try_select(8'h80 | 8'h20, 1'b0, 10, "R1 other ID");
    try_select(8'h80 | (8'h01 << OWN), 1'b1, 10, "R1 I/O high");
    run(8'h08, 1'b1, 3, 8'h00, 1'b1, -1, 8'h00);   // R5 group 0, data-in
    run(8'h28, 1'b0, 2, 8'h00, 1'b1, -1, 8'h00);   // R5 group 1, data-out
    run(8'h5F, 1'b1, 0, 8'h00, 1'b1, -1, 8'h00);   // R5 group 2, no data R8
    run(8'hA8, 1'b0, 0, 8'h00, 1'b1, -1, 8'h00);   // R5 group 5
    run(8'h60, 1'b1, 4, 8'h00, 1'b1, -1, 8'h02);   // R6 unknown group
    run(8'hE0, 1'b0, 2, 8'h00, 1'b1, -1, 8'h02);   // R6 unknown group
    run(8'h48, 1'b0, 1, 8'h00, 1'b1,  3, 8'h02);   // R7 parity error
    run(8'h00, 1'b1, 2, 8'h18, 1'b0,  2, 8'h18);   // R7 parity off, host status
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule